// File: doc/BRIEF.md
# Serial EEPROM Whole-Image Page Programmer

This block is a bus master that writes a complete image into a paged serial configuration EEPROM over a two-wire bus. One wire is a clock that the block drives. The other is a bidirectional data line that the block only ever pulls low or lets go, so an external pull-up supplies the high level. A one-cycle start pulse begins a run. The block drops its active-low enable output and then programs the device one page at a time. Each page goes out as its own message: a start condition, the write device address, a three-byte memory address, one page of data bytes, and a stop condition. The block checks the acknowledge that follows every byte.

Image bytes come in through a plain valid/ready input. Each byte that is accepted is also kept in a page-sized store. If a byte is not acknowledged, the block closes the message with a stop and sends the whole page again from its start condition, without asking for new input. After the last page, the block sends a start condition and the read device address as a probe. It releases the enable only when the device acknowledges that probe. Busy, done and error outputs report progress. Bus timing comes from a divide parameter, and the page size and page count are parameters so that smaller device variants can be programmed.

Top module: `eeprom_image_writer`

## Requirements
- R1: After reset the clock output is high, `sda_oe_o` is 0 (line released), `prog_en_n_o` is 1, and `busy_o`, `done_o`, `error_o` and `wr_ready_o` are all 0. Whenever `busy_o` is low, the clock is high and the line is released.
- R2: A start pulse seen while not busy drives `prog_en_n_o` low and `busy_o` high from the next cycle. `prog_en_n_o` stays low for as long as `busy_o` is high.
- R3: Each page goes out as one message in this order: start condition, byte 0xA6, three memory address bytes, PAGE_BYTES data bytes, stop condition. The 24-bit address is the page number shifted left by 7 (page in bits 16..7, all other bits zero), sent most significant byte first. Pages go out in ascending order from page 0.
- R4: Device address bytes and memory address bytes are sent most significant bit first. Data bytes are sent least significant bit first.
- R5: Every byte is followed by a ninth clock during which the block releases the line. The block takes a low line, sampled while the clock is high, as an acknowledge.
- R6: The data line never changes in the same cycle as a clock edge. While the clock is high, the only changes are a falling line (start) and a rising line (stop).
- R7: A data byte is accepted on a cycle where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` is high only when the next byte of the current page has never been accepted. A run that ends in done accepts exactly PAGE_BYTES×PAGE_COUNT bytes.
- R8: A missing acknowledge on any byte ends the message with a stop. The same page is then sent again from its start condition with the same data bytes, and no new input bytes are taken for it.
- R9: When one message fails MAX_RETRY+1 times in a row, the block ends with `error_o` high, `busy_o` low and `prog_en_n_o` still low. At most one of `busy_o`, `done_o` and `error_o` is high at any time.
- R10: After the last page, the block sends a start condition and byte 0xA7. If that byte is acknowledged, a stop follows, and then `prog_en_n_o` goes high in the same cycle that `done_o` goes high. If it is not acknowledged, the probe is retried under the same rule as a page.
- R11: Each clock high time within a start condition or a bit lasts exactly 2×DIV cycles.
- R12: A start pulse while `busy_o` is high has no effect on the bus traffic or the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to program the whole device |
| wr_data_i | input | 8 | Next image byte |
| wr_valid_i | input | 1 | `wr_data_i` holds a valid byte |
| wr_ready_o | output | 1 | Block takes the byte in this cycle if valid |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_o | output | 1 | Bus clock |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| prog_en_n_o | output | 1 | Active-low programming enable to the EEPROM |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run finished with an acknowledged probe |
| error_o | output | 1 | Last run gave up after repeated missing acknowledges |

## Verification
The assertions assume that the bus receiver pulls the line low only during the ninth clock of a byte and never creates a start or stop condition itself. They also assume that start pulses arrive as single cycles. The bench's receiver model meets both conditions. It decides each acknowledge from the byte it has just decoded, pulls the line only after the clock falls at the end of the eighth bit, and lets go after the clock falls at the end of the ninth. Missing acknowledges are injected only at chosen byte positions: on a data byte, on an address byte, and on the final probe. The only start pulse issued while busy is the single deliberate one that exercises R12.

// File: rtl/eepw_pkg.sv
// Package: shared types, constants and helpers for the EEPROM image programmer.
// Assumes: bus line levels are encoded as {clock level, pull-low request}.
package eepw_pkg;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_STOP  = 2'd1,
        BUS_BYTE  = 2'd2
    } bus_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_START = 3'd1,
        SQ_DEV   = 3'd2,
        SQ_ADDR  = 3'd3,
        SQ_DATA  = 3'd4,
        SQ_STOP  = 3'd5,
        SQ_DONE  = 3'd6,
        SQ_ERR   = 3'd7
    } seq_state_e;

    localparam logic [7:0] DEV_WRITE_ID = 8'hA6;
    localparam logic [7:0] DEV_PROBE_ID = 8'hA7;

    // Mirror a byte so that the LSB becomes the first bit shifted out.
    function automatic logic [7:0] mirror8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Line levels {scl, pull} for a command in a given quarter; bitv is the bit sent.
    function automatic logic [1:0] quarter_levels(input bus_cmd_e k, input logic [1:0] q,
                                                  input logic bitv);
        logic [1:0] lv;
        case (k)
            BUS_START: case (q)
                2'd0:    lv = 2'b00;
                2'd1:    lv = 2'b10;
                2'd2:    lv = 2'b11;
                default: lv = 2'b01;
            endcase
            BUS_STOP: case (q)
                2'd0:    lv = 2'b01;
                2'd1:    lv = 2'b11;
                default: lv = 2'b10;
            endcase
            default: lv = {(q == 2'd1) || (q == 2'd2), !bitv};
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/eepw_bus_engine.sv
// Bus engine: runs one start, stop or byte+acknowledge command on the two-wire bus.
// Each bit is four quarters of DIV cycles each; the line changes only while the
// clock is low, except for start/stop. Outputs are registered. The ninth bit of a
// byte is a released line, and the acknowledge is sampled at the end of quarter 2.
// Assumes: a command is offered only while the engine is inactive.
module eepw_bus_engine
    import eepw_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  bus_cmd_e   cmd_kind,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_lsb_first,
    input  logic       sda_in,
    output logic       eng_done,
    output logic       eng_ack,
    output logic       scl_o,
    output logic       pull_o
);
    localparam int QW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          active;
    bus_cmd_e      kind;
    logic [QW-1:0] qcnt;
    logic [1:0]    qph;
    logic [3:0]    bitn;
    logic [7:0]    shreg;
    logic          scl_q, pull_q, done_q, ack_q;
    logic [7:0]    load_val;
    logic          q_end, last_bit;

    assign load_val = cmd_lsb_first ? mirror8(cmd_byte) : cmd_byte;
    assign q_end    = active && (qcnt == QW'(DIV - 1));
    assign last_bit = (kind != BUS_BYTE) || (bitn == 4'd8);

    // Quarter timer, bit sequencing, registered line levels and acknowledge capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            kind   <= BUS_STOP;
            qcnt   <= '0;
            qph    <= 2'd0;
            bitn   <= 4'd0;
            shreg  <= 8'hFF;
            scl_q  <= 1'b1;
            pull_q <= 1'b0;
            done_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active && cmd_valid) begin
                active          <= 1'b1;
                kind            <= cmd_kind;
                qcnt            <= '0;
                qph             <= 2'd0;
                bitn            <= 4'd0;
                shreg           <= load_val;
                {scl_q, pull_q} <= quarter_levels(cmd_kind, 2'd0, load_val[7]);
            end else if (q_end) begin
                qcnt <= '0;
                if (kind == BUS_BYTE && qph == 2'd2 && bitn == 4'd8)
                    ack_q <= !sda_in;
                if (qph != 2'd3) begin
                    qph             <= qph + 2'd1;
                    {scl_q, pull_q} <= quarter_levels(kind, qph + 2'd1, shreg[7]);
                end else if (!last_bit) begin
                    qph             <= 2'd0;
                    bitn            <= bitn + 4'd1;
                    shreg           <= {shreg[6:0], 1'b1};
                    {scl_q, pull_q} <= quarter_levels(kind, 2'd0, shreg[6]);
                end else begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (active) begin
                qcnt <= qcnt + QW'(1);
            end
        end
    end

    assign eng_done = done_q;
    assign eng_ack  = ack_q;
    assign scl_o    = scl_q;
    assign pull_o   = pull_q;

endmodule

// File: rtl/eepw_page_store.sv
// Page store: keeps the bytes of the current page so that a failed page can be resent.
// One shared address for write and combinational read. Assumes a byte is read only
// after it has been written during the current page.
module eepw_page_store #(
    parameter int DEPTH = 128,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write the accepted byte into its page slot.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/eepw_sequencer.sv
// Sequencer: page loop, address generation, acknowledge checks, retries, final probe
// and status. Issues one bus command at a time and waits for the engine to finish it.
// Assumes: eng_done is a one-cycle pulse that follows each issued command.
module eepw_sequencer
    import eepw_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int PAGE_COUNT = 1024,
    parameter int ADDR_BYTES = 3,
    parameter int PAGE_SHIFT = 7,
    parameter int MAX_RETRY  = 3,
    localparam int IW  = $clog2(PAGE_BYTES),
    localparam int BW  = $clog2(PAGE_BYTES + 1),
    localparam int PGW = $clog2(PAGE_COUNT + 1),
    localparam int AW  = $clog2(ADDR_BYTES + 1),
    localparam int RW  = $clog2(MAX_RETRY + 1),
    localparam int MAW = ADDR_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [7:0]    wr_data_i,
    input  logic          wr_valid_i,
    output logic          wr_ready_o,
    input  logic          eng_done,
    input  logic          eng_ack,
    output logic          cmd_valid,
    output bus_cmd_e      cmd_kind,
    output logic [7:0]    cmd_byte,
    output logic          cmd_lsb_first,
    output logic          buf_we,
    output logic [IW-1:0] buf_addr,
    input  logic [7:0]    buf_rdata,
    output logic          prog_en_n_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o
);
    seq_state_e     state;
    logic           waiting, final_ph, nack_seen, en_n_q, done_q, err_q;
    logic [PGW-1:0] page;
    logic [AW-1:0]  acnt;
    logic [BW-1:0]  bcnt, fill;
    logic [RW-1:0]  retry;
    logic [MAW-1:0] mem_addr, addr_shift;
    logic           need_new, can_start;

    assign mem_addr   = MAW'(page) << PAGE_SHIFT;
    assign addr_shift = mem_addr >> (8 * (ADDR_BYTES - 1 - int'(acnt)));
    assign need_new   = (bcnt == fill);
    assign can_start  = (state == SQ_IDLE) || (state == SQ_DONE) || (state == SQ_ERR);
    assign wr_ready_o = (state == SQ_DATA) && !waiting && need_new;
    assign buf_we     = wr_ready_o && wr_valid_i;
    assign buf_addr   = IW'(bcnt);

    // Choose the next bus command for the current state.
    always_comb begin
        cmd_valid     = 1'b0;
        cmd_kind      = BUS_BYTE;
        cmd_byte      = 8'h00;
        cmd_lsb_first = 1'b0;
        case (state)
            SQ_START: begin
                cmd_valid = !waiting;
                cmd_kind  = BUS_START;
            end
            SQ_DEV: begin
                cmd_valid = !waiting;
                cmd_byte  = final_ph ? DEV_PROBE_ID : DEV_WRITE_ID;
            end
            SQ_ADDR: begin
                cmd_valid = !waiting;
                cmd_byte  = addr_shift[7:0];
            end
            SQ_DATA: begin
                cmd_lsb_first = 1'b1;
                cmd_valid     = !waiting && (!need_new || wr_valid_i);
                cmd_byte      = need_new ? wr_data_i : buf_rdata;
            end
            SQ_STOP: begin
                cmd_valid = !waiting;
                cmd_kind  = BUS_STOP;
            end
            default: ;
        endcase
    end

    // Page loop: advance on each completed command, retry or finish after stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            waiting   <= 1'b0;
            final_ph  <= 1'b0;
            nack_seen <= 1'b0;
            en_n_q    <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            page      <= '0;
            acnt      <= '0;
            bcnt      <= '0;
            fill      <= '0;
            retry     <= '0;
        end else if (start_i && can_start) begin
            state     <= SQ_START;
            waiting   <= 1'b0;
            final_ph  <= 1'b0;
            nack_seen <= 1'b0;
            en_n_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            page      <= '0;
            fill      <= '0;
            retry     <= '0;
        end else begin
            if (cmd_valid) waiting <= 1'b1;
            if (buf_we) fill <= fill + BW'(1);
            if (eng_done) begin
                waiting <= 1'b0;
                case (state)
                    SQ_START: state <= SQ_DEV;
                    SQ_DEV: begin
                        if (!eng_ack) begin
                            nack_seen <= 1'b1;
                            state     <= SQ_STOP;
                        end else if (final_ph) begin
                            state <= SQ_STOP;
                        end else begin
                            acnt  <= '0;
                            state <= SQ_ADDR;
                        end
                    end
                    SQ_ADDR: begin
                        if (!eng_ack) begin
                            nack_seen <= 1'b1;
                            state     <= SQ_STOP;
                        end else if (acnt == AW'(ADDR_BYTES - 1)) begin
                            bcnt  <= '0;
                            state <= SQ_DATA;
                        end else begin
                            acnt <= acnt + AW'(1);
                        end
                    end
                    SQ_DATA: begin
                        if (!eng_ack) begin
                            nack_seen <= 1'b1;
                            state     <= SQ_STOP;
                        end else if (bcnt == BW'(PAGE_BYTES - 1)) begin
                            state <= SQ_STOP;
                        end else begin
                            bcnt <= bcnt + BW'(1);
                        end
                    end
                    SQ_STOP: begin
                        nack_seen <= 1'b0;
                        if (nack_seen) begin
                            if (retry == RW'(MAX_RETRY)) begin
                                err_q <= 1'b1;
                                state <= SQ_ERR;
                            end else begin
                                retry <= retry + RW'(1);
                                state <= SQ_START;
                            end
                        end else if (final_ph) begin
                            en_n_q <= 1'b1;
                            done_q <= 1'b1;
                            state  <= SQ_DONE;
                        end else begin
                            retry <= '0;
                            fill  <= '0;
                            state <= SQ_START;
                            if (page == PGW'(PAGE_COUNT - 1)) final_ph <= 1'b1;
                            else page <= page + PGW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign prog_en_n_o = en_n_q;
    assign busy_o      = !can_start;
    assign done_o      = done_q;
    assign error_o     = err_q;

endmodule

// File: rtl/eeprom_image_writer.sv
// Top: whole-device page programmer for a paged serial EEPROM on a two-wire bus.
// Joins the sequencer, the page store and the bus engine. The data line is open
// drain: sda_oe_o = 1 pulls it low, and an external pull-up provides the high level.
// Assumes: PAGE_BYTES >= 2, PAGE_COUNT >= 1, MAX_RETRY >= 1, DIV >= 1.
module eeprom_image_writer
    import eepw_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int PAGE_BYTES = 128,
    parameter int PAGE_COUNT = 1024,
    parameter int ADDR_BYTES = 3,
    parameter int PAGE_SHIFT = 7,
    parameter int MAX_RETRY  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] wr_data_i,
    input  logic       wr_valid_i,
    output logic       wr_ready_o,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_oe_o,
    output logic       prog_en_n_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       error_o
);
    localparam int IW = $clog2(PAGE_BYTES);

    logic          cmd_valid, cmd_lsb_first, eng_done, eng_ack, buf_we;
    bus_cmd_e      cmd_kind;
    logic [7:0]    cmd_byte, buf_rdata;
    logic [IW-1:0] buf_addr;

    eepw_sequencer #(
        .PAGE_BYTES(PAGE_BYTES), .PAGE_COUNT(PAGE_COUNT), .ADDR_BYTES(ADDR_BYTES),
        .PAGE_SHIFT(PAGE_SHIFT), .MAX_RETRY(MAX_RETRY)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
        .eng_done(eng_done), .eng_ack(eng_ack),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
        .cmd_lsb_first(cmd_lsb_first),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .prog_en_n_o(prog_en_n_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    eepw_page_store #(.DEPTH(PAGE_BYTES), .IW(IW)) u_store (
        .clk(clk), .we(buf_we), .addr(buf_addr), .wdata(wr_data_i), .rdata(buf_rdata)
    );

    eepw_bus_engine #(.DIV(DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_byte(cmd_byte), .cmd_lsb_first(cmd_lsb_first), .sda_in(sda_i),
        .eng_done(eng_done), .eng_ack(eng_ack), .scl_o(scl_o), .pull_o(sda_oe_o)
    );

endmodule

// File: rtl/eepw_checker.sv
// Checker: port-level properties of the programmer, attached to every top instance.
module eepw_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_oe_o,
    input logic prog_en_n_o,
    input logic busy_o,
    input logic done_o,
    input logic error_o,
    input logic wr_ready_o
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_o && !sda_oe_o)); // R1
    AST_EN_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !prog_en_n_o); // R2
    AST_EDGE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_o) |-> $stable(sda_oe_o)); // R6
    AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> (busy_o && !prog_en_n_o)); // R7
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o, error_o})); // R9
    AST_ERR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !prog_en_n_o); // R9
    AST_EN_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en_n_o) |-> done_o); // R10
endmodule

bind eeprom_image_writer eepw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
    .prog_en_n_o(prog_en_n_o), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o), .wr_ready_o(wr_ready_o)
);

// File: tb/eeprom_image_writer_tb.sv
// Scoreboard bench: tasks push the expected bus events, and a bus monitor with a
// receiver model decodes the wire, pops the events and compares them.
module eeprom_image_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2, PB = 4, PC = 3, MR = 2;
    localparam int EV_START = 256, EV_STOP = 512;

    logic clk = 0, rst_n = 0, start_i = 0, wr_valid_i = 0;
    logic [7:0] wr_data_i = 8'h00;
    logic wr_ready_o, scl_o, sda_oe_o, prog_en_n_o, busy_o, done_o, error_o, sda_i;
    logic slave_pull = 0;

    int checks = 0, fails = 0, seed = 0, feed_cnt = 0, cyc = 0;
    int exp_q[$];
    int nack_left = 0, nack_idx = 0, nack_first = -1;
    bit finished = 0;

    assign sda_i = ~(sda_oe_o | slave_pull);

    eeprom_image_writer #(.DIV(DIV), .PAGE_BYTES(PB), .PAGE_COUNT(PC),
                          .ADDR_BYTES(3), .PAGE_SHIFT(7), .MAX_RETRY(MR)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_data_i(wr_data_i),
        .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .sda_i(sda_i),
        .scl_o(scl_o), .sda_oe_o(sda_oe_o), .prog_en_n_o(prog_en_n_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] data_of(input int k);
        return 8'((k * 53 + seed * 29 + 7) & 255);
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Push the expected events for one page message: start, the first nbytes bytes, stop (R3, R4).
    task automatic push_page(input int p, input int nbytes);
        int full[$];
        logic [23:0] a;
        a = 24'(p) << 7;
        full.push_back(8'hA6);
        full.push_back(int'(a[23:16]));
        full.push_back(int'(a[15:8]));
        full.push_back(int'(a[7:0]));
        for (int i = 0; i < PB; i++) full.push_back(int'(rev8(data_of(p * PB + i))));
        exp_q.push_back(EV_START);
        for (int i = 0; i < nbytes; i++) exp_q.push_back(full[i]);
        exp_q.push_back(EV_STOP);
    endtask

    task automatic push_probe();   // R10
        exp_q.push_back(EV_START);
        exp_q.push_back(8'hA7);
        exp_q.push_back(EV_STOP);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask

    task automatic wait_end();
        while (!(done_o || error_o)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Input feeder: valid pattern with gaps; counts handshakes (R7).
    bit hs_pend = 0, prev_busy = 0;
    always @(negedge clk) begin
        cyc++;
        if (busy_o && !prev_busy) feed_cnt = 0;
        prev_busy = busy_o;
        if (hs_pend) feed_cnt++;
        wr_valid_i = ((cyc % 5) != 3);
        wr_data_i  = data_of(feed_cnt);
        hs_pend    = wr_valid_i && wr_ready_o;
    end

    // Bus monitor and receiver model.
    bit prev_scl = 1, prev_line = 1, ack_rel = 0, pend_nack = 0, after_stop = 1;
    int bitcnt = 0, bim = 0, hi_cnt = 0, msg_first = 0;
    logic [7:0] sh = 0;
    always @(negedge clk) begin
        bit line, fall;
        int got;
        line = !(sda_oe_o || slave_pull);
        fall = 0;
        if (rst_n) begin
            if (scl_o) hi_cnt++;
            if (scl_o && prev_scl && prev_line && !line) begin
                got = EV_START;
                bitcnt = 0; bim = 0;
            end else if (scl_o && prev_scl && !prev_line && line) begin
                got = EV_STOP;
                after_stop = 1;
            end else begin
                got = -1;
                if (scl_o && !prev_scl) begin
                    if (bitcnt < 8) begin
                        sh = {sh[6:0], line};
                        bitcnt++;
                        if (bitcnt == 8) begin
                            got = int'(sh);
                            if (bim == 0) msg_first = int'(sh);
                            pend_nack = (nack_left > 0) && (bim == nack_idx) &&
                                        (nack_first < 0 || msg_first == nack_first);
                        end
                    end else begin
                        check(sda_oe_o == 0, "R5 line released in ninth clock", sda_oe_o, 0);
                        bitcnt = 0; bim++; ack_rel = 1;
                    end
                end else if (!scl_o && prev_scl) begin
                    fall = 1;
                end
            end
            if (got >= 0) begin
                if (exp_q.size() == 0) check(0, "R3 unexpected bus event", got, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(got == e, "R3/R4/R8 bus event order", got, e);
                end
            end
            if (fall) begin
                if (!after_stop) check(hi_cnt == 2 * DIV, "R11 clock high time", hi_cnt, 2 * DIV);
                after_stop = 0; hi_cnt = 0;
                if (ack_rel) begin
                    slave_pull = 0; ack_rel = 0;
                end else if (bitcnt == 8) begin
                    slave_pull = !pend_nack;
                    if (pend_nack) nack_left--;
                end
            end
            if (!scl_o) hi_cnt = 0;
        end
        prev_scl  = scl_o;
        prev_line = !(sda_oe_o || slave_pull);
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(scl_o == 1 && sda_oe_o == 0, "R1 lines after reset", {scl_o, sda_oe_o}, 2'b10);
        check(prog_en_n_o == 1, "R1 enable after reset", prog_en_n_o, 1);
        check({busy_o, done_o, error_o, wr_ready_o} == 0, "R1 status after reset",
              {busy_o, done_o, error_o, wr_ready_o}, 0);

        // Test 1: clean run, plus a start pulse during the run (R12)
        seed = 1;
        for (int p = 0; p < PC; p++) push_page(p, 4 + PB);
        push_probe();
        pulse_start();
        check(prog_en_n_o == 0 && busy_o == 1, "R2 enable low and busy after start",
              {prog_en_n_o, busy_o}, 2'b01);
        repeat (300) @(negedge clk);
        check(prog_en_n_o == 0, "R2 enable held low mid-run", prog_en_n_o, 0);
        pulse_start();   // R12: ignored while busy
        wait_end();
        check(done_o == 1 && error_o == 0, "R10 done after probe ack", {done_o, error_o}, 2'b10);
        check(prog_en_n_o == 1, "R10 enable released", prog_en_n_o, 1);
        check(exp_q.size() == 0, "R3 R12 all events seen", exp_q.size(), 0);
        check(feed_cnt == PC * PB, "R7 bytes accepted", feed_cnt, PC * PB);

        // Test 2: missing acknowledge on data byte 2 of page 0, resend (R8)
        seed = 2;
        nack_left = 1; nack_idx = 6; nack_first = 8'hA6;
        push_page(0, 7);
        for (int p = 0; p < PC; p++) push_page(p, 4 + PB);
        push_probe();
        pulse_start();
        wait_end();
        check(done_o == 1, "R8 run completes after resend", done_o, 1);
        check(feed_cnt == PC * PB, "R8 no extra input taken on resend", feed_cnt, PC * PB);
        check(exp_q.size() == 0, "R8 resent page events", exp_q.size(), 0);

        // Test 3: address byte never acknowledged, give up (R9)
        seed = 3;
        nack_left = MR + 1; nack_idx = 1; nack_first = -1;
        for (int r = 0; r <= MR; r++) push_page(0, 2);
        pulse_start();
        wait_end();
        check(error_o == 1 && busy_o == 0 && done_o == 0, "R9 error status",
              {error_o, busy_o, done_o}, 3'b100);
        check(prog_en_n_o == 0, "R9 enable kept low on error", prog_en_n_o, 0);
        check(exp_q.size() == 0, "R9 retry count", exp_q.size(), 0);
        check(feed_cnt == 0, "R7 no bytes taken on address failure", feed_cnt, 0);

        // Test 4: final probe missed once, then acknowledged (R10)
        seed = 4;
        nack_left = 1; nack_idx = 0; nack_first = 8'hA7;
        for (int p = 0; p < PC; p++) push_page(p, 4 + PB);
        push_probe();
        push_probe();
        pulse_start();
        wait_end();
        check(done_o == 1 && prog_en_n_o == 1, "R10 probe retry then release",
              {done_o, prog_en_n_o}, 2'b11);
        check(exp_q.size() == 0, "R10 probe events", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule